// File: doc/BRIEF.md
# DRAM Bank Machine Pool

This block is the request-tracking core of an SDRAM controller. It holds a small pool of identical trackers. Each accepted single read or write request goes to one free tracker. While it holds the request, that tracker owns the target bank. It works out whether the bank already has the right row open, has a different row open, or is closed. It then asks for a precharge, an activate and finally the column command, and each of these is requested only when that bank's timing counters allow it. The tracker returns to the pool in the cycle after its column command is taken.

Trackers are not tied to physical banks. A tracker is bound to a bank only for the life of one request, so the pool can be smaller than the number of banks. A round-robin arbiter picks one ready tracker per cycle and presents its command on a valid/ready command port. Because trackers advance on their own, a later request that hits an open row can get its column command out ahead of an earlier request that must first open its row. Data paths, refresh and the PHY sit outside this block.

Top module: `bank_mach_pool`

## Requirements
- R1: After reset all trackers are free and every bank is closed: `req_ready` is 1 and `cmd_valid` is 0.
- R2: A request is accepted (`req_valid` and `req_ready` both 1) only when a tracker is free and no busy tracker holds the same bank. While the bank is held, `req_ready` is 0 for that bank.
- R3: No more than NUM_MACH requests are outstanding at once. With every tracker busy, `req_ready` is 0.
- R4: A request whose bank is open on the requested row produces only its column command, with no precharge or activate.
- R5: A request to a closed bank produces an activate that carries the requested row on `cmd_addr`, followed by its column command.
- R6: A request to a bank open on a different row produces a precharge, then an activate, then the column command.
- R7: A column command to a bank issues at least T_RCD cycles after the activate to that bank. With the command port always ready and no competition, the gap is exactly T_RCD.
- R8: An activate to a bank issues at least T_RP cycles after the precharge to that bank.
- R9: A precharge to a bank issues at least T_RAS cycles after the activate to that bank.
- R10: Every accepted request gets exactly one column command, to its bank and carrying its column on `cmd_addr`. The command is read for a request with `req_write`=0 and write for a request with `req_write`=1.
- R11: At most one command is issued per cycle, on the edge where `cmd_valid` and `cmd_ready` are both 1. While `cmd_ready` is 0 and nothing new arrives, the offered command stays valid and unchanged. `cmd_kind` encodes 0 as precharge, 1 as activate, 2 as read and 3 as write.
- R12: Column commands may leave in a different order from request arrival. A later row-hit request is not held behind an earlier request that is still opening its row.
- R13: A tracker is released in the cycle after its column command issues. Two row-hit requests to the same bank are therefore accepted two cycles apart when the command port is always ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | A free tracker exists and the bank is not held |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | $clog2(NUM_BANK) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_valid | output | 1 | A tracker offers a command |
| cmd_ready | input | 1 | The command is taken this cycle |
| cmd_kind | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank | output | $clog2(NUM_BANK) | Bank of the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row for activate, column for read or write, zero for precharge |

## Verification
The timing properties assume that reset is held for at least one edge before traffic starts. They also assume the block is the only source of commands to the banks, so that its own command stream is a complete history of every bank. The hold property assumes the consumer may leave `cmd_ready` low for any number of cycles but never withdraws a command on its side. The stimulus asserts reset for several cycles and drives only bank numbers inside the configured range. It changes requests and `cmd_ready` just after the clock edge and never issues commands from anywhere but the block.

// File: rtl/bmp_pkg.sv
// Shared types for the bank machine pool.
// Assumes nothing beyond a two-bit command field at the block's edge.
package bmp_pkg;

    // DRAM command encoding seen on cmd_kind
    typedef enum logic [1:0] {
        CMD_PRE = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_WR  = 2'd3
    } dram_cmd_e;

    // Phase of one tracker
    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_PRE  = 2'd1,
        MS_ACT  = 2'd2,
        MS_COL  = 2'd3
    } mach_state_e;

endpackage

// File: rtl/bmp_gap_timer.sv
// Minimum-gap timer: after start, ok stays low for LOAD-1 further cycles,
// so the next dependent event cannot come earlier than LOAD cycles later.
// Assumes LOAD >= 1.
module bmp_gap_timer #(
    parameter int unsigned LOAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ok
);
    localparam int unsigned CNT_W = $clog2(LOAD + 1);

    logic [CNT_W-1:0] cnt;

    // Load on start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(LOAD - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign ok = (cnt == '0);

endmodule

// File: rtl/bmp_bank_table.sv
// Per-bank state: open flag, open row and three gap timers (activate to
// column, precharge to activate, activate to precharge).
// Assumes the issued command stream is the only thing that changes banks.
module bmp_bank_table
    import bmp_pkg::*;
#(
    parameter int unsigned NUM_BANK = 8,
    parameter int unsigned ROW_W    = 14,
    parameter int unsigned T_RCD    = 4,
    parameter int unsigned T_RP     = 4,
    parameter int unsigned T_RAS    = 10,
    localparam int unsigned BANK_W  = $clog2(NUM_BANK)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               issue,
    input  dram_cmd_e                          issue_kind,
    input  logic [BANK_W-1:0]                  issue_bank,
    input  logic [ROW_W-1:0]                   issue_row,
    output logic [NUM_BANK-1:0]                bank_open,
    output logic [NUM_BANK-1:0][ROW_W-1:0]     bank_row,
    output logic [NUM_BANK-1:0]                rcd_ok,
    output logic [NUM_BANK-1:0]                rp_ok,
    output logic [NUM_BANK-1:0]                ras_ok
);
    logic is_act;
    logic is_pre;

    assign is_act = issue && (issue_kind == CMD_ACT);
    assign is_pre = issue && (issue_kind == CMD_PRE);

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        logic hit_bank;
        assign hit_bank = (issue_bank == BANK_W'(b));

        // Track open state and open row of this bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[b] <= 1'b0;
                bank_row[b]  <= '0;
            end else if (is_act && hit_bank) begin
                bank_open[b] <= 1'b1;
                bank_row[b]  <= issue_row;
            end else if (is_pre && hit_bank) begin
                bank_open[b] <= 1'b0;
            end
        end

        bmp_gap_timer #(.LOAD(T_RCD)) u_rcd (
            .clk(clk), .rst_n(rst_n), .start(is_act && hit_bank), .ok(rcd_ok[b]));
        bmp_gap_timer #(.LOAD(T_RAS)) u_ras (
            .clk(clk), .rst_n(rst_n), .start(is_act && hit_bank), .ok(ras_ok[b]));
        bmp_gap_timer #(.LOAD(T_RP)) u_rp (
            .clk(clk), .rst_n(rst_n), .start(is_pre && hit_bank), .ok(rp_ok[b]));
    end

endmodule

// File: rtl/bmp_machine.sv
// One request tracker. On load it latches the request and starts at the
// first command the bank needs. It steps precharge -> activate -> column
// as each command is granted, and frees itself when the column is granted.
// Assumes the caller loads it only while idle and feeds it its own bank's timers.
module bmp_machine
    import bmp_pkg::*;
#(
    parameter int unsigned BANK_W = 3,
    parameter int unsigned ROW_W  = 14,
    parameter int unsigned COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_write,
    input  logic [BANK_W-1:0] ld_bank,
    input  logic [ROW_W-1:0]  ld_row,
    input  logic [COL_W-1:0]  ld_col,
    input  logic              ld_open,
    input  logic              ld_hit,
    input  logic              grant,
    input  logic              rcd_ok,
    input  logic              rp_ok,
    input  logic              ras_ok,
    output logic              busy,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              want,
    output dram_cmd_e         want_kind
);
    mach_state_e state;
    logic        is_write;

    // Phase sequencing and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= MS_IDLE;
            is_write <= 1'b0;
            bank     <= '0;
            row      <= '0;
            col      <= '0;
        end else begin
            case (state)
                MS_IDLE: if (load) begin
                    is_write <= ld_write;
                    bank     <= ld_bank;
                    row      <= ld_row;
                    col      <= ld_col;
                    state    <= ld_hit ? MS_COL : (ld_open ? MS_PRE : MS_ACT);
                end
                MS_PRE:  if (grant) state <= MS_ACT;
                MS_ACT:  if (grant) state <= MS_COL;
                MS_COL:  if (grant) state <= MS_IDLE;
                default: state <= MS_IDLE;
            endcase
        end
    end

    // Offer a command once the bank's gap for this phase has elapsed
    always_comb begin
        want      = 1'b0;
        want_kind = CMD_PRE;
        case (state)
            MS_PRE: begin want = ras_ok; want_kind = CMD_PRE; end
            MS_ACT: begin want = rp_ok;  want_kind = CMD_ACT; end
            MS_COL: begin want = rcd_ok; want_kind = is_write ? CMD_WR : CMD_RD; end
            default: ;
        endcase
    end

    assign busy = (state != MS_IDLE);

endmodule

// File: rtl/bmp_rr_arb.sv
// Round-robin picker: the search starts just after the last granted index.
// The pointer moves only when the grant is taken (advance).
// Assumes N >= 2.
module bmp_rr_arb #(
    parameter int unsigned N   = 4,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] sel,
    output logic          any
);
    logic [IW-1:0] ptr;

    // Pick the first requester at or after the pointer, wrapping around
    always_comb begin
        gnt = '0;
        sel = '0;
        any = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            int idx;
            idx = int'(ptr) + i;
            if (idx >= int'(N)) idx = idx - int'(N);
            if (!any && req[idx]) begin
                gnt[idx] = 1'b1;
                sel      = IW'(idx);
                any      = 1'b1;
            end
        end
    end

    // Move priority past the winner once its command is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance && any) begin
            ptr <= (int'(sel) == int'(N) - 1) ? '0 : sel + 1'b1;
        end
    end

endmodule

// File: rtl/bank_mach_pool.sv
// Pool of request trackers for an SDRAM controller. It hands each accepted
// request to the lowest free tracker, keeps one tracker per bank at a time
// and issues one command per cycle chosen round-robin among ready trackers.
// Assumes req_bank < NUM_BANK and that no other agent commands the banks.
module bank_mach_pool
    import bmp_pkg::*;
#(
    parameter int unsigned NUM_MACH = 4,
    parameter int unsigned NUM_BANK = 8,
    parameter int unsigned ROW_W    = 14,
    parameter int unsigned COL_W    = 10,
    parameter int unsigned T_RCD    = 4,
    parameter int unsigned T_RP     = 4,
    parameter int unsigned T_RAS    = 10,
    localparam int unsigned BANK_W  = $clog2(NUM_BANK),
    localparam int unsigned MACH_W  = $clog2(NUM_MACH),
    localparam int unsigned ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr
);
    logic [NUM_MACH-1:0]               mach_busy;
    logic [NUM_MACH-1:0][BANK_W-1:0]   mach_bank;
    logic [NUM_MACH-1:0][ROW_W-1:0]    m_row;
    logic [NUM_MACH-1:0][COL_W-1:0]    m_col;
    logic [NUM_MACH-1:0]               m_want;
    dram_cmd_e                         m_kind [NUM_MACH];
    logic [NUM_MACH-1:0]               gnt;
    logic [MACH_W-1:0]                 sel;
    logic                              any_want;
    logic [NUM_MACH-1:0]               load_vec;
    logic [MACH_W-1:0]                 free_idx;
    logic                              any_free;
    logic                              owned;
    logic                              accept;
    logic                              fire;
    logic                              lk_open;
    logic                              lk_hit;
    dram_cmd_e                         sel_kind;

    logic [NUM_BANK-1:0]               bank_open;
    logic [NUM_BANK-1:0][ROW_W-1:0]    bank_row;
    logic [NUM_BANK-1:0]               rcd_ok;
    logic [NUM_BANK-1:0]               rp_ok;
    logic [NUM_BANK-1:0]               ras_ok;

    // Lowest-index free tracker
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int m = int'(NUM_MACH) - 1; m >= 0; m--) begin
            if (!mach_busy[m]) begin
                free_idx = MACH_W'(m);
                any_free = 1'b1;
            end
        end
    end

    // Is the requested bank already held by a busy tracker
    always_comb begin
        owned = 1'b0;
        for (int m = 0; m < int'(NUM_MACH); m++) begin
            if (mach_busy[m] && (mach_bank[m] == req_bank)) owned = 1'b1;
        end
    end

    assign req_ready = any_free && !owned;
    assign accept    = req_valid && req_ready;
    assign lk_open   = bank_open[req_bank];
    assign lk_hit    = lk_open && (bank_row[req_bank] == req_row);

    // One-hot load strobe to the chosen free tracker
    always_comb begin
        load_vec = '0;
        if (accept) load_vec[free_idx] = 1'b1;
    end

    for (genvar m = 0; m < NUM_MACH; m++) begin : g_mach
        bmp_machine #(
            .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
        ) u_mach (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_vec[m]),
            .ld_write  (req_write),
            .ld_bank   (req_bank),
            .ld_row    (req_row),
            .ld_col    (req_col),
            .ld_open   (lk_open),
            .ld_hit    (lk_hit),
            .grant     (gnt[m] && cmd_ready),
            .rcd_ok    (rcd_ok[mach_bank[m]]),
            .rp_ok     (rp_ok[mach_bank[m]]),
            .ras_ok    (ras_ok[mach_bank[m]]),
            .busy      (mach_busy[m]),
            .bank      (mach_bank[m]),
            .row       (m_row[m]),
            .col       (m_col[m]),
            .want      (m_want[m]),
            .want_kind (m_kind[m])
        );
    end

    bmp_rr_arb #(.N(NUM_MACH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (m_want),
        .advance (cmd_ready),
        .gnt     (gnt),
        .sel     (sel),
        .any     (any_want)
    );

    assign cmd_valid = any_want;
    assign fire      = any_want && cmd_ready;
    assign sel_kind  = m_kind[sel];

    // Drive the winning tracker's command onto the port
    always_comb begin
        cmd_kind = sel_kind;
        cmd_bank = mach_bank[sel];
        case (sel_kind)
            CMD_ACT:        cmd_addr = ADDR_W'(m_row[sel]);
            CMD_RD, CMD_WR: cmd_addr = ADDR_W'(m_col[sel]);
            default:        cmd_addr = '0;
        endcase
    end

    bmp_bank_table #(
        .NUM_BANK(NUM_BANK), .ROW_W(ROW_W),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
    ) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (fire),
        .issue_kind (sel_kind),
        .issue_bank (mach_bank[sel]),
        .issue_row  (m_row[sel]),
        .bank_open  (bank_open),
        .bank_row   (bank_row),
        .rcd_ok     (rcd_ok),
        .rp_ok      (rp_ok),
        .ras_ok     (ras_ok)
    );

endmodule

// File: rtl/bank_mach_pool_chk.sv
// Property checker for the bank machine pool. It keeps its own per-bank
// counters of cycles since the last activate and precharge, rebuilt from the
// command port alone. Assumes reset is applied before traffic.
module bank_mach_pool_chk #(
    parameter int unsigned NUM_MACH = 4,
    parameter int unsigned NUM_BANK = 8,
    parameter int unsigned T_RCD    = 4,
    parameter int unsigned T_RP     = 4,
    parameter int unsigned T_RAS    = 10,
    localparam int unsigned BANK_W  = $clog2(NUM_BANK)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            req_valid,
    input logic                            req_ready,
    input logic [BANK_W-1:0]               req_bank,
    input logic                            cmd_valid,
    input logic                            cmd_ready,
    input logic [1:0]                      cmd_kind,
    input logic [BANK_W-1:0]               cmd_bank,
    input logic [NUM_MACH-1:0]             mach_busy,
    input logic [NUM_MACH-1:0][BANK_W-1:0] mach_bank,
    input logic [NUM_BANK-1:0]             bank_open
);
    logic                      fire;
    logic [NUM_BANK-1:0][15:0] since_act;
    logic [NUM_BANK-1:0][15:0] since_pre;
    logic                      held;

    assign fire = cmd_valid && cmd_ready;

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_cnt
        // Cycles since this bank's last activate, saturating
        always_ff @(posedge clk) begin
            if (!rst_n) since_act[b] <= 16'hFFFF;
            else if (fire && cmd_kind == 2'd1 && cmd_bank == BANK_W'(b)) since_act[b] <= 16'd1;
            else if (since_act[b] != 16'hFFFF) since_act[b] <= since_act[b] + 16'd1;
        end
        // Cycles since this bank's last precharge, saturating
        always_ff @(posedge clk) begin
            if (!rst_n) since_pre[b] <= 16'hFFFF;
            else if (fire && cmd_kind == 2'd0 && cmd_bank == BANK_W'(b)) since_pre[b] <= 16'd1;
            else if (since_pre[b] != 16'hFFFF) since_pre[b] <= since_pre[b] + 16'd1;
        end
    end

    // Whether a busy tracker already holds the requested bank
    always_comb begin
        held = 1'b0;
        for (int m = 0; m < int'(NUM_MACH); m++) begin
            if (mach_busy[m] && mach_bank[m] == req_bank) held = 1'b1;
        end
    end

    // R7
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_kind[1] |-> since_act[cmd_bank] >= 16'(T_RCD));

    // R8
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_kind == 2'd1 |-> since_pre[cmd_bank] >= 16'(T_RP));

    // R9
    ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_kind == 2'd0 |-> since_act[cmd_bank] >= 16'(T_RAS));

    // R5
    act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_kind == 2'd1 |-> !bank_open[cmd_bank]);

    // R6
    pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cmd_kind == 2'd0 |-> bank_open[cmd_bank]);

    // R2
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> !held);

    // R3
    pool_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mach_busy) |-> !req_ready);

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid);

endmodule

bind bank_mach_pool bank_mach_pool_chk #(
    .NUM_MACH(NUM_MACH), .NUM_BANK(NUM_BANK),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_bank),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_bank  (cmd_bank),
    .mach_busy (mach_busy),
    .mach_bank (mach_bank),
    .bank_open (bank_open)
);

// File: tb/bank_mach_pool_test.sv
// Self-checking bench: directed cases for each bank situation, then a long
// sweep over banks, rows and command-port stalls. A monitor rebuilds bank
// state from the command stream and scores each request.
module bank_mach_pool_test;
    localparam int NM = 4;
    localparam int NB = 8;
    localparam int RW = 4;
    localparam int CW = 4;
    localparam int TRCD = 3;
    localparam int TRP  = 2;
    localparam int TRAS = 6;
    localparam int BW = $clog2(NB);
    localparam int AW = (RW > CW) ? RW : CW;
    localparam int LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_kind;
    logic [BW-1:0] cmd_bank;
    logic [AW-1:0] cmd_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit sweep = 1'b0;

    // scoreboard and model of the banks, rebuilt from the ports
    bit pend [NB];
    int exp_row [NB], exp_col [NB], exp_wr [NB];
    bit m_open [NB];
    int m_row [NB];
    int act_cyc [NB], pre_cyc [NB], col_cyc [NB], col_gap [NB];
    int hcnt [NB], first_kind [NB], second_kind [NB];
    int outstanding = 0;

    bank_mach_pool #(
        .NUM_MACH(NM), .NUM_BANK(NB), .ROW_W(RW), .COL_W(CW),
        .T_RCD(TRCD), .T_RP(TRP), .T_RAS(TRAS)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            pend[b] = 0; m_open[b] = 0; m_row[b] = 0;
            act_cyc[b] = -1000; pre_cyc[b] = -1000; col_cyc[b] = 0; col_gap[b] = 0;
            hcnt[b] = 0; first_kind[b] = -1; second_kind[b] = -1;
            exp_row[b] = 0; exp_col[b] = 0; exp_wr[b] = 0;
        end
    end

    // Monitor: score every accepted request and every issued command
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_valid && req_ready) begin
                int b;
                b = int'(req_bank);
                chk(!pend[b], "R2 accept on held bank", 1, 0);
                pend[b] = 1; exp_row[b] = int'(req_row); exp_col[b] = int'(req_col);
                exp_wr[b] = int'(req_write); hcnt[b] = 0;
                outstanding++;
            end
            if (cmd_valid && cmd_ready) begin
                int b, k;
                b = int'(cmd_bank);
                k = int'(cmd_kind);
                if (hcnt[b] == 0) first_kind[b] = k;
                if (hcnt[b] == 1) second_kind[b] = k;
                hcnt[b]++;
                case (k)
                    0: begin
                        chk(m_open[b], "R6 precharge to closed bank", 0, 1);
                        chk(cyc - act_cyc[b] >= TRAS, "R9 activate-to-precharge gap", cyc - act_cyc[b], TRAS);
                        m_open[b] = 0; pre_cyc[b] = cyc;
                    end
                    1: begin
                        chk(!m_open[b], "R5 activate to open bank", 1, 0);
                        chk(cyc - pre_cyc[b] >= TRP, "R8 precharge-to-activate gap", cyc - pre_cyc[b], TRP);
                        chk(pend[b] && int'(cmd_addr) == exp_row[b], "R5 activate row", int'(cmd_addr), exp_row[b]);
                        m_open[b] = 1; m_row[b] = int'(cmd_addr); act_cyc[b] = cyc;
                    end
                    default: begin
                        chk(pend[b], "R10 column without request", 0, 1);
                        chk(m_open[b] && m_row[b] == exp_row[b], "R4 column on wrong row", m_row[b], exp_row[b]);
                        chk(cyc - act_cyc[b] >= TRCD, "R7 activate-to-column gap", cyc - act_cyc[b], TRCD);
                        chk(k == 2 + exp_wr[b], "R10 column direction", k, 2 + exp_wr[b]);
                        chk(int'(cmd_addr) == exp_col[b], "R10 column address", int'(cmd_addr), exp_col[b]);
                        pend[b] = 0; outstanding--;
                        col_cyc[b] = cyc; col_gap[b] = cyc - act_cyc[b];
                    end
                endcase
            end
            chk(outstanding <= NM, "R3 occupancy", outstanding, NM);
        end
    end

    // Offer one request and wait for it to be taken; returns the accept cycle
    task automatic send(input int b, input int r, input int c, input int w, output int acc);
        req_valid = 1'b1;
        req_bank = BW'(b); req_row = RW'(r); req_col = CW'(c); req_write = w[0];
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        acc = cyc;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Wait until every request has had its column command
    task automatic drain;
        forever begin
            @(negedge clk); #1;
            if (outstanding == 0 && !cmd_valid) break;
        end
        @(posedge clk); #1;
    endtask

    // Stall pattern on the command port during the sweep
    always @(posedge clk) begin
        if (sweep) #1 cmd_ready = ((cyc % 7) != 3) && ((cyc % 11) != 5);
    end

    initial begin
        int t1, t2, k0, b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1 no command after reset", int'(cmd_valid), 0);
        @(posedge clk); #1;
        cmd_ready = 1'b1;

        // closed bank: activate then column, exact tRCD gap
        send(0, 5, 7, 0, t1); drain;
        chk(hcnt[0] == 2, "R5 command count", hcnt[0], 2);
        chk(first_kind[0] == 1, "R5 first command", first_kind[0], 1);
        chk(col_gap[0] == TRCD, "R7 minimum gap used", col_gap[0], TRCD);

        // row hit: column only
        send(0, 5, 9, 1, t1); drain;
        chk(hcnt[0] == 1, "R4 command count", hcnt[0], 1);
        chk(first_kind[0] == 3, "R4 write command", first_kind[0], 3);

        // row conflict: precharge, activate, column
        send(0, 6, 1, 0, t1); drain;
        chk(hcnt[0] == 3, "R6 command count", hcnt[0], 3);
        chk(first_kind[0] == 0, "R6 first command", first_kind[0], 0);
        chk(second_kind[0] == 1, "R6 second command", second_kind[0], 1);

        // release: back-to-back row hits to one bank
        send(0, 6, 2, 0, t1);
        send(0, 6, 3, 1, t2);
        chk(t2 - t1 == 2, "R13 re-accept spacing", t2 - t1, 2);
        drain;

        // stalled command port: ownership, full pool, held command
        cmd_ready = 1'b0;
        send(1, 0, 4, 0, t1);
        req_valid = 1'b1; req_bank = BW'(1); req_row = '0; req_col = '0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R2 held bank blocks request", int'(req_ready), 0);
        @(posedge clk); #1; req_valid = 1'b0;
        send(2, 0, 5, 1, t1);
        send(3, 0, 6, 0, t1);
        send(4, 0, 7, 1, t1);
        req_valid = 1'b1; req_bank = BW'(5);
        @(negedge clk);
        chk(req_ready == 1'b0, "R3 full pool blocks request", int'(req_ready), 0);
        chk(outstanding == NM, "R3 pool full count", outstanding, NM);
        @(posedge clk); #1; req_valid = 1'b0;
        @(negedge clk);
        k0 = int'(cmd_kind); b0 = int'(cmd_bank);
        repeat (3) @(negedge clk);
        chk(cmd_valid == 1'b1, "R11 command held valid", int'(cmd_valid), 1);
        chk(int'(cmd_kind) == k0 && int'(cmd_bank) == b0, "R11 command held stable", int'(cmd_bank), b0);
        chk(outstanding == NM, "R11 nothing issued while stalled", outstanding, NM);
        @(posedge clk); #1;
        cmd_ready = 1'b1;
        drain;

        // out-of-order: later row hit overtakes earlier row conflict
        send(3, 2, 5, 0, t1);
        send(2, 0, 6, 1, t2);
        drain;
        chk(col_cyc[2] < col_cyc[3], "R12 hit column first", col_cyc[2], col_cyc[3]);

        // sweep over banks, rows, columns and directions with stalls
        sweep = 1'b1;
        for (int i = 0; i < 600; i++) begin
            send((i * 5 + i / 8) % NB, (i / 3) % 3, i % 16, i % 2, t1);
        end
        sweep = 1'b0;
        @(posedge clk); #1;
        cmd_ready = 1'b1;
        drain;
        chk(outstanding == 0, "R10 every request completed", outstanding, 0);
        for (int b = 0; b < NB; b++) begin
            chk(!pend[b], "R10 no request left pending", int'(pend[b]), 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule